// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block runs single register transactions on a two-wire serial management bus, of the kind used to configure and query an Ethernet PHY. A command names a read or a write, a 5-bit register number and, for writes, a 16-bit value. The block then generates the whole frame on its own: management clock, data-out, output enable for an external tri-state buffer, and a sampled data-in line. One command is in flight at a time. When the frame ends, a one-cycle response strobe reports the completion and carries the 16-bit value read back.

Commands enter through a valid/ready handshake. `cmd_ready` is high exactly when the block is idle. A command is taken on the clock edge where `cmd_valid` and `cmd_ready` are both high. The producer must hold the command fields stable while `cmd_valid` is high and `cmd_ready` is low. The response side applies no back-pressure: `rsp_valid` is a single-cycle strobe that cannot be stalled. `rsp_data` keeps its value until the next command is accepted.

The management clock rate is set at build time. Each bit slot lasts 2×(DIV+1) system clocks. In every slot the clock is low for the first DIV+1 cycles and high for the last DIV+1 cycles. The PHY address field is always zero.

Top module: `mgmt_frame_master`

## Requirements
- R1: While `rst_n` is low: `mdc`, `mdo`, `mdo_oe`, `busy` and `rsp_valid` are 0, and `cmd_ready` is 1.
- R2: A command is accepted on a clock edge where `cmd_valid` is 1 and `cmd_ready` is 1. From the next cycle, `busy` is 1 and `cmd_ready` is 0 until the completion cycle. A new command can be accepted in the completion cycle itself.
- R3: A command presented while `busy` is 1 is ignored. The running frame continues unchanged, and no further frame follows it.
- R4: Each bit slot is DIV+1 system cycles with `mdc` low, followed by DIV+1 cycles with `mdc` high. While idle, `mdc`, `mdo` and `mdo_oe` are all 0.
- R5: Every frame opens with 33 slots in which `mdo_oe`=1 and `mdo`=1.
- R6: Next come two start slots carrying 0 then 1, then two opcode slots. The opcode is 0,1 for a write (`cmd_write`=1) and 1,0 for a read (`cmd_write`=0). `mdo_oe` stays 1 throughout.
- R7: Next come five slots of 0 for the PHY address, then the five bits of `cmd_reg`, most significant bit first.
- R8: For a read, `mdo_oe` and `mdo` are 0 for one turnaround slot and then for 16 data slots. `mdi` is captured only at the rising `mdc` edge of each data slot, first bit into `rsp_data[15]`. The value of `mdi` at any other time has no effect on `rsp_data`.
- R9: For a write, the turnaround slots drive 1 then 0, followed by `cmd_wdata` in 16 slots, bit 15 first. `mdo_oe` stays 1 throughout.
- R10: `mdo` and `mdo_oe` change only in cycles where `mdc` is low.
- R11: At the end of the high half of the last slot, `rsp_valid` is 1 for exactly one cycle. In that same cycle `busy`, `mdc` and `mdo_oe` are 0. `rsp_data` then holds the captured value after a read and zero after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_write | input | 1 | 1 = write transaction, 0 = read transaction |
| cmd_reg | input | REG_W (5) | Target register number |
| cmd_wdata | input | DATA_W (16) | Value to write |
| busy | output | 1 | A frame is in progress |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_data | output | DATA_W (16) | Read result (zero after a write) |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Serial data out |
| mdo_oe | output | 1 | Output enable for the data line |
| mdi | input | 1 | Serial data in |

## Verification
The bench builds the block with DIV=1, so each half of a slot lasts two system cycles. This exercises the divider wrapping inside a half while keeping a full frame near 260 cycles. The other parameters keep their defaults: a 33-slot preamble and 5-bit address, register and 16-bit data fields. Every slot position of both frame shapes therefore falls on the real field boundaries. During read frames the responder drives the inverse bit in the high half and alternating values outside the data slots, so a capture taken on the wrong edge or in the wrong slot shows up directly in `rsp_data`.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  // Field currently on the wire, decoded from the slot index
  typedef enum logic [2:0] {
    SEG_PRE,
    SEG_START,
    SEG_OP,
    SEG_PHY,
    SEG_REG,
    SEG_TA,
    SEG_DATA
  } seg_e;
endpackage

// File: rtl/mgmt_bit_timer.sv
// Divides the system clock into bit slots: low half then high half.
module mgmt_bit_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc_hi,
  output logic rise_stb,
  output logic slot_stb
);
  localparam int CW = (DIV > 0) ? $clog2(DIV + 1) : 1;
  localparam logic [CW-1:0] CMAX = CW'(DIV);

  logic [CW-1:0] cnt_q;
  logic          hi_q;
  logic          wrap;

  assign wrap = run && (cnt_q == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      hi_q  <= ~hi_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign mdc_hi   = hi_q;
  assign rise_stb = wrap & ~hi_q;  // last cycle of low half: clock rises at this edge
  assign slot_stb = wrap & hi_q;   // last cycle of high half: slot ends at this edge
endmodule

// File: rtl/mgmt_slot_decode.sv
// Counts bit slots and maps the count onto frame fields.
module mgmt_slot_decode
  import mgmt_pkg::*;
#(
  parameter int PRE_LEN = 33,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic step,
  input  logic is_wr,
  output seg_e seg,
  output logic second,
  output logic last
);
  localparam int TOTAL = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int SW    = $clog2(TOTAL + 1);

  localparam logic [SW-1:0] B_START = SW'(PRE_LEN);
  localparam logic [SW-1:0] B_OP    = SW'(PRE_LEN + 2);
  localparam logic [SW-1:0] B_PHY   = SW'(PRE_LEN + 4);
  localparam logic [SW-1:0] B_REG   = SW'(PRE_LEN + 4 + PHY_W);
  localparam logic [SW-1:0] B_TA    = SW'(PRE_LEN + 4 + PHY_W + REG_W);
  localparam logic [SW-1:0] B_D_RD  = SW'(PRE_LEN + 4 + PHY_W + REG_W + 1);
  localparam logic [SW-1:0] B_D_WR  = SW'(PRE_LEN + 4 + PHY_W + REG_W + 2);
  localparam logic [SW-1:0] L_RD    = SW'(PRE_LEN + 4 + PHY_W + REG_W + 1 + DATA_W - 1);
  localparam logic [SW-1:0] L_WR    = SW'(PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W - 1);

  logic [SW-1:0] slot_q;
  logic [SW-1:0] data_base;

  assign data_base = is_wr ? B_D_WR : B_D_RD;
  assign last      = (slot_q == (is_wr ? L_WR : L_RD));
  assign second    = (slot_q == B_START + SW'(1)) ||
                     (slot_q == B_OP + SW'(1))    ||
                     (slot_q == B_TA + SW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                slot_q <= '0;
    else if (start)            slot_q <= '0;
    else if (step && !last)    slot_q <= slot_q + SW'(1);
  end

  always_comb begin
    if      (slot_q < B_START)   seg = SEG_PRE;
    else if (slot_q < B_OP)      seg = SEG_START;
    else if (slot_q < B_PHY)     seg = SEG_OP;
    else if (slot_q < B_REG)     seg = SEG_PHY;
    else if (slot_q < B_TA)      seg = SEG_REG;
    else if (slot_q < data_base) seg = SEG_TA;
    else                         seg = SEG_DATA;
  end
endmodule

// File: rtl/mgmt_line_drive.sv
// Holds the outgoing register number and the data shifter, and drives the lines.
module mgmt_line_drive
  import mgmt_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              wr_in,
  input  logic [REG_W-1:0]  reg_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              active,
  input  logic              is_wr,
  input  seg_e              seg,
  input  logic              second,
  input  logic              rise_stb,
  input  logic              slot_stb,
  input  logic              mdi,
  output logic              mdo,
  output logic              mdo_oe,
  output logic [DATA_W-1:0] sr_data
);
  logic [REG_W-1:0]  reg_sr;
  logic [DATA_W-1:0] dat_sr;

  // One shifter serves both directions: writes drain it, reads fill it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_sr <= '0;
      dat_sr <= '0;
    end else if (load) begin
      reg_sr <= reg_in;
      dat_sr <= wr_in ? wdata_in : '0;
    end else begin
      if (slot_stb && seg == SEG_REG)
        reg_sr <= reg_sr << 1;
      if (is_wr && seg == SEG_DATA && slot_stb)
        dat_sr <= dat_sr << 1;
      else if (!is_wr && seg == SEG_DATA && rise_stb)
        dat_sr <= {dat_sr[DATA_W-2:0], mdi};
    end
  end

  always_comb begin
    mdo_oe = 1'b0;
    mdo    = 1'b0;
    if (active) begin
      mdo_oe = 1'b1;
      case (seg)
        SEG_PRE:   mdo = 1'b1;
        SEG_START: mdo = second;
        SEG_OP:    mdo = is_wr ? second : ~second;
        SEG_PHY:   mdo = 1'b0;
        SEG_REG:   mdo = reg_sr[REG_W-1];
        SEG_TA: begin
          mdo_oe = is_wr;
          mdo    = is_wr & ~second;
        end
        SEG_DATA: begin
          mdo_oe = is_wr;
          mdo    = is_wr & dat_sr[DATA_W-1];
        end
        default:   mdo = 1'b0;
      endcase
    end
  end

  assign sr_data = dat_sr;
endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
  import mgmt_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int PRE_LEN = 33,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mdc,
  output logic              mdo,
  output logic              mdo_oe,
  input  logic              mdi
);
  logic busy_q, wr_q, rsp_q;
  logic accept, finish;
  logic mdc_hi, rise_stb, slot_stb;
  logic second, last;
  seg_e seg;

  assign accept = cmd_valid & ~busy_q;
  assign finish = slot_stb & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      rsp_q  <= 1'b0;
    end else begin
      rsp_q <= finish;
      if (accept) begin
        busy_q <= 1'b1;
        wr_q   <= cmd_write;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end

  mgmt_bit_timer #(.DIV(DIV)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .mdc_hi   (mdc_hi),
    .rise_stb (rise_stb),
    .slot_stb (slot_stb)
  );

  mgmt_slot_decode #(
    .PRE_LEN (PRE_LEN),
    .PHY_W   (PHY_W),
    .REG_W   (REG_W),
    .DATA_W  (DATA_W)
  ) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .step   (slot_stb),
    .is_wr  (wr_q),
    .seg    (seg),
    .second (second),
    .last   (last)
  );

  mgmt_line_drive #(
    .REG_W  (REG_W),
    .DATA_W (DATA_W)
  ) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .wr_in    (cmd_write),
    .reg_in   (cmd_reg),
    .wdata_in (cmd_wdata),
    .active   (busy_q),
    .is_wr    (wr_q),
    .seg      (seg),
    .second   (second),
    .rise_stb (rise_stb),
    .slot_stb (slot_stb),
    .mdi      (mdi),
    .mdo      (mdo),
    .mdo_oe   (mdo_oe),
    .sr_data  (rsp_data)
  );

  assign cmd_ready = ~busy_q;
  assign busy      = busy_q;
  assign rsp_valid = rsp_q;
  assign mdc       = mdc_hi;
endmodule

// File: rtl/mgmt_frame_master_chk.sv
module mgmt_frame_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic rsp_valid,
  input logic mdc,
  input logic mdo,
  input logic mdo_oe
);
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdo_oe && !mdo));

  assert_change_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdo) && $stable(mdo_oe)));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_done_ends_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!busy && $past(busy)));

  assert_busy_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || rsp_valid));
endmodule

bind mgmt_frame_master mgmt_frame_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .mdc       (mdc),
  .mdo       (mdo),
  .mdo_oe    (mdo_oe)
);

// File: tb/test_mgmt_frame_master.sv
module test_mgmt_frame_master;
  localparam int DIV = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid, cmd_write, mdi;
  logic [4:0]  cmd_reg;
  logic [15:0] cmd_wdata;
  logic        cmd_ready, busy, rsp_valid, mdc, mdo, mdo_oe;
  logic [15:0] rsp_data;

  always #10 clk = ~clk;

  mgmt_frame_master #(.DIV(DIV)) i_mgmt_frame_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_write (cmd_write),
    .cmd_reg   (cmd_reg),
    .cmd_wdata (cmd_wdata),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .mdc       (mdc),
    .mdo       (mdo),
    .mdo_oe    (mdo_oe),
    .mdi       (mdi)
  );

  // Reference model: one entry per expected cycle {mdc, oe, mdo, mdi to drive}
  logic [3:0]  expq[$];
  string       tagq[$];
  int          checks = 0;
  int          errors = 0;
  bit          pend = 0;
  bit          first_ent = 0;
  bit          nz = 0;
  bit          finished = 0;
  logic [15:0] exp_data = '0;
  string       done_tag = "R11";
  string       idle_tag = "R4";

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void add_slot(bit oe, bit d, bit in_lo, bit in_hi, string tag);
    for (int h = 0; h < 2; h++) begin
      for (int c = 0; c <= DIV; c++) begin
        expq.push_back({(h == 1), oe, d, (h == 1) ? in_hi : in_lo});
        tagq.push_back((h == 1) ? "R10" : tag);
      end
    end
  endfunction

  function automatic void plain(bit oe, bit d, string tag);
    nz = ~nz;
    add_slot(oe, d, nz, ~nz, tag);
  endfunction

  function automatic void build(bit wr, logic [4:0] r, logic [15:0] wd, logic [15:0] pat);
    for (int i = 0; i < 33; i++) plain(1'b1, 1'b1, "R5");
    plain(1'b1, 1'b0, "R6");
    plain(1'b1, 1'b1, "R6");
    plain(1'b1, ~wr, "R6");
    plain(1'b1, wr, "R6");
    for (int i = 0; i < 5; i++) plain(1'b1, 1'b0, "R7");
    for (int i = 4; i >= 0; i--) plain(1'b1, r[i], "R7");
    if (wr) begin
      plain(1'b1, 1'b1, "R9");
      plain(1'b1, 1'b0, "R9");
      for (int i = 15; i >= 0; i--) plain(1'b1, wd[i], "R9");
      exp_data = '0;
      done_tag = "R11";
    end else begin
      add_slot(1'b0, 1'b0, ~pat[15], pat[15], "R8");
      for (int i = 15; i >= 0; i--) add_slot(1'b0, 1'b0, pat[i], ~pat[i], "R8");
      exp_data = pat;
      done_tag = "R8";
    end
    first_ent = 1'b1;
  endfunction

  // Compare at the falling edge, then drive inputs for the next rising edge
  task automatic step(input bit v, input bit wr, input logic [4:0] r,
                      input logic [15:0] wd, input logic [15:0] pat);
    logic [3:0] e;
    string      t;
    @(negedge clk);
    if (expq.size() > 0) begin
      e = expq.pop_front();
      t = tagq.pop_front();
      if (first_ent) t = "R2";
      first_ent = 1'b0;
      check(t, "frame {mdc,oe,mdo,busy,ready,rsp_valid}",
            {26'd0, mdc, mdo_oe, mdo, busy, cmd_ready, rsp_valid},
            {26'd0, e[3], e[2], e[1], 3'b100});
      mdi = e[0];
      if (expq.size() == 0) pend = 1'b1;
    end else begin
      check(pend ? "R11" : idle_tag, "idle {mdc,oe,mdo,busy,ready,rsp_valid}",
            {26'd0, mdc, mdo_oe, mdo, busy, cmd_ready, rsp_valid},
            {26'd0, 3'b000, 2'b01, pend});
      if (pend) check(done_tag, "rsp_data", {16'd0, rsp_data}, {16'd0, exp_data});
      pend = 1'b0;
      nz = ~nz;
      mdi = nz;
    end
    cmd_valid = v;
    cmd_write = wr;
    cmd_reg   = r;
    cmd_wdata = wd;
    if (v && expq.size() == 0 && !pend) build(wr, r, wd, pat);
  endtask

  task automatic drain();
    while (expq.size() > 0 || pend) step(1'b0, 1'b0, 5'd0, 16'd0, 16'd0);
  endtask

  task automatic run_cmd(input bit wr, input logic [4:0] r,
                         input logic [15:0] wd, input logic [15:0] pat);
    step(1'b1, wr, r, wd, pat);
    drain();
    step(1'b0, 1'b0, 5'd0, 16'd0, 16'd0);
  endtask

  initial begin
    cmd_valid = 1'b0;
    cmd_write = 1'b0;
    cmd_reg   = '0;
    cmd_wdata = '0;
    mdi       = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check("R1", "reset {mdc,oe,mdo,busy,ready,rsp_valid}",
          {26'd0, mdc, mdo_oe, mdo, busy, cmd_ready, rsp_valid}, {26'd0, 6'b000010});
    rst_n = 1'b1;
    repeat (2) step(1'b0, 1'b0, 5'd0, 16'd0, 16'd0);

    run_cmd(1'b0, 5'h01, 16'h0000, 16'hA5C3);   // R8 read, mixed pattern
    run_cmd(1'b1, 5'h1F, 16'h8001, 16'h0000);   // R9 write, edge bits
    run_cmd(1'b0, 5'h10, 16'h0000, 16'hFFFF);   // R8 all ones
    run_cmd(1'b0, 5'h0A, 16'h0000, 16'h0000);   // R8 all zeros

    // R3: commands offered during a frame are ignored
    step(1'b1, 1'b1, 5'h00, 16'h7FFE, 16'h0000);
    for (int k = 0; k < 40; k++) step(1'b1, 1'b0, 5'h15, 16'h1234, 16'h5555);
    drain();
    idle_tag = "R3";
    repeat (4) step(1'b0, 1'b0, 5'd0, 16'd0, 16'd0);
    idle_tag = "R4";

    // R2: back-to-back command taken in the completion cycle
    step(1'b1, 1'b0, 5'h0C, 16'h0000, 16'h3C96);
    while (expq.size() > 0) step(1'b0, 1'b0, 5'd0, 16'd0, 16'd0);
    step(1'b1, 1'b1, 5'h12, 16'hBEEF, 16'h0000);
    drain();
    repeat (2) step(1'b0, 1'b0, 5'd0, 16'd0, 16'd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule